// File: doc/BRIEF.md
# Four-Channel DMA Channel Programming Register File

This block is the host-side register interface of a four-channel DMA controller. A host reaches it over a narrow I/O bus: a 4-bit port offset, an 8-bit write data byte, an 8-bit read data byte, and single-cycle read and write strobes. Each channel holds a 16-bit address register and a 16-bit count register. Both are reached through one 8-bit port each, so a full value takes two byte accesses. One byte-pointer flag, shared by all channels, decides whether an access hits the low byte or the high byte. Software returns that flag to the low byte by writing to a dedicated clear port.

The block also holds a command byte, a status byte, and a mode field and a mask bit for each channel. The mask bits can be changed one channel at a time, loaded all at once, or cleared all at once, and a master-clear port returns the controller to its idle state. The masks, modes, command byte and the channel address and count values are driven straight out to the transfer engine. The engine sends back per-channel terminal-count pulses and live request levels, which appear in the status byte. The transfer sequencing and the upper address (page) bits are not part of this block.

Top module: `dmareg_file`

## Requirements
- R1: After reset all four mask bits are 1, the command byte and every mode field are 0, every address and count register is 0, the byte pointer selects the low byte, and the status byte reads 0 while no request is active.
- R2: The address register of channel c sits at port offset 2c and its count register at offset 2c+1. When the pointer starts at the low byte, two writes to the same port load bits 7:0 and then bits 15:8, and the new value appears on `chan_addr`/`chan_count` (channel c in bits 16c+15:16c). Registers of other channels are unchanged.
- R3: Every read or write to offsets 0 to 7 flips the byte pointer, whichever register it hits. Any write to offset 0xC returns the pointer to the low byte.
- R4: A read of offsets 0 to 7 returns the byte of that register that the pointer selects: the low byte when the pointer is clear, the high byte when it is set.
- R5: A write to offset 0xA changes one mask bit only. Data bits 1:0 select the channel, data bit 2 = 1 sets its mask and bit 2 = 0 clears it, and bits 7:3 are ignored.
- R6: A write to offset 0xB stores data bits 7:2 into the 6-bit mode field of the channel selected by data bits 1:0 (channel c in `chan_mode` bits 6c+5:6c). The other channels' mode fields are unchanged.
- R7: A write to offset 0xF loads all four mask bits from data bits 3:0 (bit c for channel c). A write of any value to offset 0xE clears all mask bits.
- R8: A write to offset 0xD (master clear) sets all mask bits, clears the command byte, returns the pointer to the low byte and clears the latched terminal-count bits. Address, count and mode registers keep their values.
- R9: A write to offset 0x8 loads the command byte. A read of offset 0x8 returns the status byte: bits 3:0 are the terminal-count flags, each set by a pulse on `eng_tc` and held until a status read, and bits 7:4 are the live `eng_req` levels. A status read clears the flags in the next cycle.
- R10: Reads of offsets 0x9 and 0xA to 0xF return 0 and change no state, including the pointer. Writes to offset 0x9 change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Port offset of the access |
| io_wdata | input | 8 | Write data byte |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_rdata | output | 8 | Read data byte, valid during the read strobe |
| eng_tc | input | 4 | Terminal-count pulses from the transfer engine, one per channel |
| eng_req | input | 4 | Live request levels from the transfer engine |
| chan_mask | output | 4 | Mask bit per channel |
| chan_mode | output | 24 | Mode field per channel, 6 bits each |
| chan_cmd | output | 8 | Command byte |
| chan_addr | output | 64 | Address register per channel, 16 bits each |
| chan_count | output | 64 | Count register per channel, 16 bits each |

## Verification
The assertions check the per-cycle rules on every clock:
- the pointer flips on each register access, returns low on a clear, and otherwise holds;
- a single-mask, mask-all or mode write lands in the right channel;
- master clear forces its fixed values;
- terminal-count pulses are latched;
- a channel register holds its value when it is not written.

Only the bench scenarios can show byte order across sequences of accesses. This covers a read that flips the pointer before the next write, and read-back of every channel's address and count. It also covers status clearing after a read, and whether accesses to the write-only ports really leave every register unchanged.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  localparam int BYTE_W = 8;
  localparam int REG_W  = 16;
  localparam int OFF_W  = 4;

  typedef enum logic [OFF_W-1:0] {
    OFF_CMDSTAT = 4'h8,
    OFF_SPARE   = 4'h9,
    OFF_SMASK   = 4'hA,
    OFF_MODE    = 4'hB,
    OFF_CLRPTR  = 4'hC,
    OFF_MCLR    = 4'hD,
    OFF_CLRMASK = 4'hE,
    OFF_MASKALL = 4'hF
  } ctl_off_e;

  // Replace one byte of a 16-bit register; hi selects the upper byte.
  function automatic logic [REG_W-1:0] merge_byte(input logic [REG_W-1:0] cur,
                                                  input logic [BYTE_W-1:0] b,
                                                  input logic hi);
    merge_byte = hi ? {b, cur[BYTE_W-1:0]} : {cur[REG_W-1:BYTE_W], b};
  endfunction

  // Select one byte of a 16-bit register for read-back.
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [REG_W-1:0] v,
                                                  input logic hi);
    pick_byte = hi ? v[REG_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

endpackage

// File: rtl/dmareg_ptr.sv
module dmareg_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic flip_en,
  input  logic clr_en,
  output logic hi_sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)       hi_sel <= 1'b0;
    else if (clr_en)  hi_sel <= 1'b0;
    else if (flip_en) hi_sel <= ~hi_sel;
  end

  // R3: each register access flips the pointer
  assert_ptr_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_en && !clr_en) |=> (hi_sel != $past(hi_sel)));

  // R3, R8: clear forces the low byte
  assert_ptr_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !hi_sel);

  // R10: no access, no movement
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!flip_en && !clr_en) |=> $stable(hi_sel));
endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_addr,
  input  logic              wr_cnt,
  input  logic              hi_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [REG_W-1:0]  addr_q,
  output logic [REG_W-1:0]  cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_addr) addr_q <= merge_byte(addr_q, wdata, hi_sel);
      if (wr_cnt)  cnt_q  <= merge_byte(cnt_q, wdata, hi_sel);
    end
  end

  // R2: registers hold unless written
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_addr |=> $stable(addr_q));
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cnt |=> $stable(cnt_q));
  // R2: a write touches only the selected byte
  assert_byte_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr && !hi_sel) |=> (addr_q[REG_W-1:BYTE_W] == $past(addr_q[REG_W-1:BYTE_W])));
endmodule

// File: rtl/dmareg_ctrl.sv
module dmareg_ctrl
  import dmareg_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int MODE_W = 6,
  localparam int CSEL_W = $clog2(NCH)
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [BYTE_W-1:0]     wdata,
  input  logic                  ev_cmd_wr,
  input  logic                  ev_stat_rd,
  input  logic                  ev_smask,
  input  logic                  ev_mode,
  input  logic                  ev_mclr,
  input  logic                  ev_clrmask,
  input  logic                  ev_maskall,
  input  logic [NCH-1:0]        eng_tc,
  input  logic [NCH-1:0]        eng_req,
  output logic [NCH-1:0]        mask_q,
  output logic [NCH*MODE_W-1:0] mode_flat,
  output logic [BYTE_W-1:0]     cmd_q,
  output logic [2*NCH-1:0]      status
);
  logic [MODE_W-1:0] mode_q [NCH];
  logic [NCH-1:0]    tc_q;
  logic [CSEL_W-1:0] sel;

  assign sel    = wdata[CSEL_W-1:0];
  assign status = {eng_req, tc_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      cmd_q  <= '0;
      tc_q   <= '0;
    end else begin
      if (ev_mclr) begin
        mask_q <= '1;
        cmd_q  <= '0;
        tc_q   <= eng_tc;
      end else begin
        if (ev_cmd_wr)  cmd_q <= wdata;
        if (ev_clrmask) mask_q <= '0;
        else if (ev_maskall) mask_q <= wdata[NCH-1:0];
        else if (ev_smask)   mask_q[sel] <= wdata[2];
        tc_q <= (tc_q & ~{NCH{ev_stat_rd}}) | eng_tc;
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_mode
    always_ff @(posedge clk) begin
      if (!rst_n)                         mode_q[c] <= '0;
      else if (ev_mode && sel == CSEL_W'(c)) mode_q[c] <= wdata[BYTE_W-1:BYTE_W-MODE_W];
    end
    assign mode_flat[c*MODE_W +: MODE_W] = mode_q[c];
  end

  assert_smask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_smask && !ev_mclr) |=> (mask_q[$past(sel)] == $past(wdata[2])));
  assert_maskall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_maskall |=> (mask_q == $past(wdata[NCH-1:0])));
  assert_clrmask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clrmask |=> (mask_q == '0));
  assert_mclr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mclr |=> (mask_q == '1 && cmd_q == '0));
  assert_tc_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_tc) |=> ((tc_q & $past(eng_tc)) == $past(eng_tc)));
  assert_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mode |=> (mode_q[$past(sel)] == $past(wdata[BYTE_W-1:BYTE_W-MODE_W])));
endmodule

// File: rtl/dmareg_file.sv
module dmareg_file
  import dmareg_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int MODE_W = 6
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [3:0]            io_addr,
  input  logic [7:0]            io_wdata,
  input  logic                  io_wr,
  input  logic                  io_rd,
  output logic [7:0]            io_rdata,
  input  logic [NCH-1:0]        eng_tc,
  input  logic [NCH-1:0]        eng_req,
  output logic [NCH-1:0]        chan_mask,
  output logic [NCH*MODE_W-1:0] chan_mode,
  output logic [7:0]            chan_cmd,
  output logic [NCH*16-1:0]     chan_addr,
  output logic [NCH*16-1:0]     chan_count
);
  localparam int CSEL_W  = $clog2(NCH);
  localparam int NREGPRT = 2 * NCH;

  logic              is_reg, acc_reg, hi_sel, clr_ptr;
  logic [CSEL_W-1:0] reg_ch;
  logic              reg_is_cnt;
  logic              ev_cmd_wr, ev_stat_rd, ev_smask, ev_mode;
  logic              ev_clrptr, ev_mclr, ev_clrmask, ev_maskall;
  logic [REG_W-1:0]  addr_q [NCH];
  logic [REG_W-1:0]  cnt_q  [NCH];
  logic [2*NCH-1:0]  status;

  assign is_reg     = (32'(io_addr) < NREGPRT);
  assign acc_reg    = is_reg && (io_wr || io_rd);
  assign reg_ch     = io_addr[CSEL_W:1];
  assign reg_is_cnt = io_addr[0];

  assign ev_cmd_wr  = io_wr && io_addr == OFF_CMDSTAT;
  assign ev_stat_rd = io_rd && !io_wr && io_addr == OFF_CMDSTAT;
  assign ev_smask   = io_wr && io_addr == OFF_SMASK;
  assign ev_mode    = io_wr && io_addr == OFF_MODE;
  assign ev_clrptr  = io_wr && io_addr == OFF_CLRPTR;
  assign ev_mclr    = io_wr && io_addr == OFF_MCLR;
  assign ev_clrmask = io_wr && io_addr == OFF_CLRMASK;
  assign ev_maskall = io_wr && io_addr == OFF_MASKALL;
  assign clr_ptr    = ev_clrptr || ev_mclr;

  dmareg_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .flip_en(acc_reg), .clr_en(clr_ptr), .hi_sel(hi_sel)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic hit;
    assign hit = io_wr && is_reg && reg_ch == CSEL_W'(c);
    dmareg_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .wr_addr(hit && !reg_is_cnt), .wr_cnt(hit && reg_is_cnt),
      .hi_sel(hi_sel), .wdata(io_wdata),
      .addr_q(addr_q[c]), .cnt_q(cnt_q[c])
    );
    assign chan_addr[c*REG_W +: REG_W]  = addr_q[c];
    assign chan_count[c*REG_W +: REG_W] = cnt_q[c];
  end

  dmareg_ctrl #(.NCH(NCH), .MODE_W(MODE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wdata(io_wdata),
    .ev_cmd_wr(ev_cmd_wr), .ev_stat_rd(ev_stat_rd), .ev_smask(ev_smask),
    .ev_mode(ev_mode), .ev_mclr(ev_mclr), .ev_clrmask(ev_clrmask),
    .ev_maskall(ev_maskall), .eng_tc(eng_tc), .eng_req(eng_req),
    .mask_q(chan_mask), .mode_flat(chan_mode), .cmd_q(chan_cmd), .status(status)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd && !io_wr) begin
      if (is_reg)
        io_rdata = pick_byte(reg_is_cnt ? cnt_q[reg_ch] : addr_q[reg_ch], hi_sel);
      else if (io_addr == OFF_CMDSTAT)
        io_rdata = BYTE_W'(status);
    end
  end

  // R10: control ports never drive read data
  assert_ctl_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !is_reg && io_addr != OFF_CMDSTAT) |-> (io_rdata == '0));
endmodule

// File: tb/dmareg_file_test.sv
module dmareg_file_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic [3:0]  eng_tc = '0, eng_req = '0;
  logic [3:0]  chan_mask;
  logic [23:0] chan_mode;
  logic [7:0]  chan_cmd;
  logic [63:0] chan_addr, chan_count;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_addr [4];
  logic [15:0] m_cnt  [4];
  logic [5:0]  m_mode [4];
  logic [3:0]  m_mask, m_tc;
  logic [7:0]  m_cmd;
  logic        m_ptr;

  always #2.5 clk = ~clk;

  dmareg_file uut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_wr(io_wr), .io_rd(io_rd), .io_rdata(io_rdata), .eng_tc(eng_tc),
    .eng_req(eng_req), .chan_mask(chan_mask), .chan_mode(chan_mode),
    .chan_cmd(chan_cmd), .chan_addr(chan_addr), .chan_count(chan_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    int ch;
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
    ch = int'(a) / 2;
    if (a < 4'h8) begin
      if (a[0]) m_cnt[ch]  = m_ptr ? {d, m_cnt[ch][7:0]}  : {m_cnt[ch][15:8], d};
      else      m_addr[ch] = m_ptr ? {d, m_addr[ch][7:0]} : {m_addr[ch][15:8], d};
      m_ptr = ~m_ptr;
    end else case (a)
      4'h8: m_cmd = d;
      4'hA: m_mask[d[1:0]] = d[2];
      4'hB: m_mode[d[1:0]] = d[7:2];
      4'hC: m_ptr = 1'b0;
      4'hD: begin m_ptr = 1'b0; m_mask = 4'hF; m_cmd = '0; m_tc = '0; end
      4'hE: m_mask = '0;
      4'hF: m_mask = d[3:0];
      default: ;
    endcase
  endtask

  task automatic rd(input string req, input logic [3:0] a);
    logic [7:0] exp;
    logic [15:0] v;
    int ch;
    ch = int'(a) / 2;
    exp = '0;
    if (a < 4'h8) begin
      v = a[0] ? m_cnt[ch] : m_addr[ch];
      exp = m_ptr ? v[15:8] : v[7:0];
    end else if (a == 4'h8) exp = {eng_req, m_tc};
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 chk(req, 64'(io_rdata), 64'(exp));
    @(posedge clk); #1;
    io_rd = 1'b0;
    if (a < 4'h8) m_ptr = ~m_ptr;
    if (a == 4'h8) m_tc = '0;
  endtask

  task automatic tc_pulse(input logic [3:0] v);
    @(negedge clk);
    eng_tc = v;
    @(posedge clk); #1;
    eng_tc = '0;
    m_tc = m_tc | v;
  endtask

  task automatic chk_outputs(input string req);
    logic [63:0] ea, ec;
    logic [23:0] em;
    for (int c = 0; c < 4; c++) begin
      ea[c*16 +: 16] = m_addr[c];
      ec[c*16 +: 16] = m_cnt[c];
      em[c*6 +: 6]   = m_mode[c];
    end
    chk({req, " addr"}, chan_addr, ea);
    chk({req, " count"}, chan_count, ec);
    chk({req, " mode"}, 64'(chan_mode), 64'(em));
    chk({req, " mask"}, 64'(chan_mask), 64'(m_mask));
    chk({req, " cmd"}, 64'(chan_cmd), 64'(m_cmd));
  endtask

  initial begin
    #(5 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin m_addr[c] = '0; m_cnt[c] = '0; m_mode[c] = '0; end
    m_mask = 4'hF; m_tc = '0; m_cmd = '0; m_ptr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    chk_outputs("R1");
    rd("R1 status", 4'h8);
    rd("R1 ptr low", 4'h0);
    wr(4'hC, 8'h00);

    // R2, R4: load every register low then high, read back
    for (int c = 0; c < 4; c++)
      for (int k = 0; k < 2; k++) begin
        logic [15:0] v;
        v = 16'(16'h1357 * (c * 2 + k + 1) + 16'h00F1 * k);
        wr(4'(c * 2 + k), v[7:0]);
        wr(4'(c * 2 + k), v[15:8]);
      end
    chk_outputs("R2");
    for (int a = 0; a < 8; a++) begin
      rd("R4 low", 4'(a));
      rd("R4 high", 4'(a));
    end

    // R3: a read flips the pointer before the next write
    wr(4'hC, 8'h77);
    wr(4'h0, 8'hAA);
    rd("R3 read after write gives high byte", 4'h0);
    wr(4'hC, 8'h00);
    rd("R3 cleared pointer reads low", 4'h1);
    wr(4'h2, 8'h5C);
    chk_outputs("R3 write after read hits high byte");
    wr(4'hC, 8'h00);

    // R5: single mask sweep
    for (int c = 0; c < 4; c++)
      for (int b = 0; b < 2; b++) begin
        wr(4'hA, 8'hF0 | 8'(b << 2) | 8'(c));
        chk("R5 single mask", 64'(chan_mask), 64'(m_mask));
      end

    // R7: mask-all sweep and clear-all
    for (int v = 0; v < 16; v++) begin
      wr(4'hF, 8'hA0 | 8'(v));
      chk("R7 mask all", 64'(chan_mask), 64'(v));
    end
    wr(4'hE, 8'h5A);
    chk("R7 clear masks", 64'(chan_mask), 64'h0);

    // R6: mode per channel
    for (int c = 0; c < 4; c++) begin
      logic [5:0] p;
      p = 6'h15 ^ 6'(c * 7);
      wr(4'hB, {p, 2'(c)});
      chk_outputs("R6");
    end

    // R9: command write, status latch and clear
    wr(4'h8, 8'h3C);
    chk("R9 command", 64'(chan_cmd), 64'h3C);
    @(negedge clk); eng_req = 4'b1010;
    tc_pulse(4'b0101);
    rd("R9 status with flags", 4'h8);
    rd("R9 status after clear", 4'h8);

    // R10: control-port reads return 0 and leave the pointer; spare write ignored
    for (int a = 9; a < 16; a++) rd("R10 control read", 4'(a));
    rd("R10 pointer still low", 4'h4);
    wr(4'hC, 8'h00);
    wr(4'h9, 8'hFF);
    chk_outputs("R10 spare write");
    rd("R10 pointer after spare write", 4'h6);

    // R8: master clear
    wr(4'hE, 8'h00);
    wr(4'h8, 8'h99);
    tc_pulse(4'b0011);
    wr(4'hD, 8'h00);
    chk_outputs("R8");
    rd("R8 status flags cleared", 4'h8);
    rd("R8 pointer low", 4'h3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule